// File: doc/BRIEF.md
# Reset Source Aggregator

This block gathers the reset requests of a chip (power-on detect, an external active-low reset pin, a software reset strobe, a watchdog timeout, a brown-out detect, and three core fault signals: a trap conflict, an illegal opcode and an access to an uninitialized working register) into a single active-high system reset. It stretches that reset so it never releases less than a fixed number of clocks after the last request goes away.

Every source that causes a reset leaves a sticky flag in an 8-bit status word. Software reads the word and can rewrite it at any time to set or clear flags. Rewriting it never resets anything. Power-on forces the word to a fixed image.

The four asynchronous sources (power-on, pin, brown-out, watchdog) are re-timed by two flops. The pin then passes a glitch filter. The brown-out source is gated by a 2-bit mode, a software enable and the sleep state.

Top module: `rst_source_agg`

## Requirements
- R1: `sysrst_o` goes high on the clock edge after any enabled request is seen. For the core-side sources (`sw_rst_i`, `trap_cfl_i`, `bad_op_i`, `uninit_w_i`) this is the first edge after the input rises.
- R2: Each source sets its own status bit: 0 power-on, 1 brown-out, 2 pin, 3 software, 4 watchdog, 5 trap conflict, 6 illegal opcode, 7 uninitialized register. Simultaneous sources set all their bits.
- R3: While power-on detect is active, the status word is forced to 8'h03 (bits 1 and 0 set, all others clear), whatever else happens that cycle.
- R4: A write with `wr_en_i` high replaces the status word with `wr_data_i` on the next edge. A write never asserts `sysrst_o`.
- R5: When a write and a hardware set hit the same bit in one cycle, the bit ends up set.
- R6: The pin reset is recognised only after the re-timed pin has been low for 4 consecutive clocks. A low pulse of 3 clocks has no effect on `sysrst_o` or on the status word.
- R7: Brown-out gating by `bor_mode_i`: 2'b00 never, 2'b01 only when `sw_bor_en_i` is 1, 2'b10 only when `sleep_i` is 0, 2'b11 always.
- R8: After the last request is gone, `sysrst_o` stays high for exactly 8 more clock edges and then falls on a clock edge.
- R9: The asynchronous sources pass two flops first. A change on power-on, brown-out or watchdog reaches the status word and `sysrst_o` on the third edge after it.
- R10: After `rst`, the status word is 0 and `sysrst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high register initialisation |
| por_det_i | input | 1 | Power-on detect, asynchronous, active high |
| pin_rst_n_i | input | 1 | External reset pin, asynchronous, active low |
| bor_det_i | input | 1 | Brown-out detect, asynchronous, active high |
| wdt_to_i | input | 1 | Watchdog timeout, asynchronous, active high |
| sw_rst_i | input | 1 | Software reset strobe, synchronous |
| trap_cfl_i | input | 1 | Trap conflict, synchronous |
| bad_op_i | input | 1 | Illegal opcode, synchronous |
| uninit_w_i | input | 1 | Uninitialized register access, synchronous |
| bor_mode_i | input | 2 | Brown-out gating mode |
| sw_bor_en_i | input | 1 | Software brown-out enable |
| sleep_i | input | 1 | Device is sleeping |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Status write value |
| status_o | output | 8 | Sticky reset cause flags |
| sysrst_o | output | 1 | System reset, active high |

## Verification
The bench sends the pin 3-clock and 4-clock low pulses. A filter that is off by one either lets the short glitch reset the chip or ignores a valid pin reset. It counts the stretch window edge by edge, which exposes a release that comes one clock early or late. It writes zero to a flag in the very cycle a fault sets it: if the write wins, the reset cause is lost. It also walks the four brown-out modes with the sleep and software enable inputs set against each mode, where a swapped code would show up as a missing or spurious reset. It checks that power-on overrides a prior software pattern with the 03 image after the synchroniser delay.

// File: rtl/rst_agg_pkg.sv
package rst_agg_pkg;

    localparam int NSRC = 8;

    typedef enum logic [2:0] {
        SRC_POR    = 3'd0,
        SRC_BOR    = 3'd1,
        SRC_PIN    = 3'd2,
        SRC_SW     = 3'd3,
        SRC_WDT    = 3'd4,
        SRC_TRAP   = 3'd5,
        SRC_OPC    = 3'd6,
        SRC_UNINIT = 3'd7
    } src_idx_e;

    typedef enum logic [1:0] {
        BOR_OFF   = 2'b00,
        BOR_SOFT  = 2'b01,
        BOR_AWAKE = 2'b10,
        BOR_ON    = 2'b11
    } bor_mode_e;

    // packed MSB first so bit positions match src_idx_e
    typedef struct packed {
        logic uninit;
        logic bad_op;
        logic trap;
        logic wdt;
        logic sw;
        logic pin;
        logic bor;
        logic por;
    } src_vec_t;

    localparam logic [NSRC-1:0] POR_IMAGE =
        (NSRC'(1) << SRC_POR) | (NSRC'(1) << SRC_BOR);

    function automatic logic bor_allowed(bor_mode_e mode, logic soft_en, logic asleep);
        logic ok;
        unique case (mode)
            BOR_OFF:   ok = 1'b0;
            BOR_SOFT:  ok = soft_en;
            BOR_AWAKE: ok = ~asleep;
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rst_sync_bank.sv
module rst_sync_bank #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
            end
        end
        assign q_o[g] = stab_q;
    end

endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_low_i,
    output logic req_o
);

    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!pin_low_i) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign req_o = (run_q == FULL);

    // R6: a recognised pin reset needs the pin low just before
    a_r6_needs_low: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(pin_low_i));
    // R6: a released pin drops the request on the next edge
    a_r6_release_clears: assert property (@(posedge clk) disable iff (rst)
        !pin_low_i |=> !req_o);

endmodule

// File: rtl/rst_hold_stretch.sv
module rst_hold_stretch #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic active_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (req_i) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = (left_q != '0);

    // R8: release only after a cycle without any request
    a_r8_release_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> !$past(req_i));

endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
    import rst_agg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            por_i,
    input  logic [NSRC-1:0] hw_set_i,
    input  logic            wr_en_i,
    input  logic [NSRC-1:0] wr_data_i,
    output logic [NSRC-1:0] status_o
);

    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] base;

    always_comb begin
        base = wr_en_i ? wr_data_i : stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (por_i) begin
            stat_q <= POR_IMAGE;
        end else begin
            stat_q <= base | hw_set_i;
        end
    end

    assign status_o = stat_q;

    // R3: power-on forces the fixed image
    a_r3_por_image: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (status_o == POR_IMAGE));
    // R5: hardware set bits are present on the next edge
    a_r5_hw_wins: assert property (@(posedge clk) disable iff (rst)
        (!por_i && hw_set_i != '0) |=> ((status_o & $past(hw_set_i)) == $past(hw_set_i)));
    // R4: a write without competing sources lands as written
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !por_i && hw_set_i == '0) |=> (status_o == $past(wr_data_i)));

endmodule

// File: rtl/rst_source_agg.sv
module rst_source_agg
    import rst_agg_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_det_i,
    input  logic       pin_rst_n_i,
    input  logic       bor_det_i,
    input  logic       wdt_to_i,
    input  logic       sw_rst_i,
    input  logic       trap_cfl_i,
    input  logic       bad_op_i,
    input  logic       uninit_w_i,
    input  logic [1:0] bor_mode_i,
    input  logic       sw_bor_en_i,
    input  logic       sleep_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] status_o,
    output logic       sysrst_o
);

    localparam int NASYNC = 4;
    localparam int A_POR = 0;
    localparam int A_PIN = 1;
    localparam int A_BOR = 2;
    localparam int A_WDT = 3;
    localparam logic [NASYNC-1:0] ASYNC_IDLE = NASYNC'(1) << A_PIN;

    logic [NASYNC-1:0] async_raw;
    logic [NASYNC-1:0] async_s;
    logic              pin_req;
    src_vec_t          req;
    logic              any_req;

    assign async_raw[A_POR] = por_det_i;
    assign async_raw[A_PIN] = pin_rst_n_i;
    assign async_raw[A_BOR] = bor_det_i;
    assign async_raw[A_WDT] = wdt_to_i;

    rst_sync_bank #(
        .W      (NASYNC),
        .RST_VAL(ASYNC_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(async_raw),
        .q_o(async_s)
    );

    rst_pin_filter #(
        .FILT_LEN(FILT_LEN)
    ) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin_low_i(~async_s[A_PIN]),
        .req_o    (pin_req)
    );

    always_comb begin
        req        = '0;
        req.por    = async_s[A_POR];
        req.pin    = pin_req;
        req.bor    = async_s[A_BOR] &
                     bor_allowed(bor_mode_e'(bor_mode_i), sw_bor_en_i, sleep_i);
        req.wdt    = async_s[A_WDT];
        req.sw     = sw_rst_i;
        req.trap   = trap_cfl_i;
        req.bad_op = bad_op_i;
        req.uninit = uninit_w_i;
    end

    assign any_req = |req;

    rst_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .por_i    (req.por),
        .hw_set_i (req),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .status_o (status_o)
    );

    rst_hold_stretch #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .req_i   (any_req),
        .active_o(sysrst_o)
    );

    // R1: any enabled request asserts the system reset next edge
    a_r1_any_asserts: assert property (@(posedge clk) disable iff (rst)
        any_req |=> sysrst_o);
    // R4: writes alone never start a reset
    a_r4_write_no_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !any_req) |=> !$rose(sysrst_o));
    // R7: brown-out mode off never raises the brown-out flag
    a_r7_off_no_flag: assert property (@(posedge clk) disable iff (rst)
        (bor_mode_i == 2'b00 && !async_s[A_POR] && !wr_en_i) |=> !$rose(status_o[1]));

endmodule

// File: tb/tb_rst_source_agg.sv
module tb_rst_source_agg;

    logic       clk = 1'b0;
    logic       rst;
    logic       por_det_i, pin_rst_n_i, bor_det_i, wdt_to_i;
    logic       sw_rst_i, trap_cfl_i, bad_op_i, uninit_w_i;
    logic [1:0] bor_mode_i;
    logic       sw_bor_en_i, sleep_i, wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] status_o;
    logic       sysrst_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    rst_source_agg dut (
        .clk(clk), .rst(rst),
        .por_det_i(por_det_i), .pin_rst_n_i(pin_rst_n_i),
        .bor_det_i(bor_det_i), .wdt_to_i(wdt_to_i),
        .sw_rst_i(sw_rst_i), .trap_cfl_i(trap_cfl_i),
        .bad_op_i(bad_op_i), .uninit_w_i(uninit_w_i),
        .bor_mode_i(bor_mode_i), .sw_bor_en_i(sw_bor_en_i), .sleep_i(sleep_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .sysrst_o(sysrst_o)
    );

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s sysrst actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic nedge(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_status(logic [7:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_idle();
        nedge(14);
        chk1("R8 idle", sysrst_o, 1'b0);
    endtask

    task automatic t_reset();
        chk8("R10 reset", status_o, 8'h00);
        chk1("R10 reset", sysrst_o, 1'b0);
    endtask

    task automatic t_write();
        write_status(8'hFF);
        chk8("R4 write ff", status_o, 8'hFF);
        nedge(5);
        chk1("R4 no reset from write", sysrst_o, 1'b0);
        write_status(8'h5A);
        chk8("R4 write 5a", status_o, 8'h5A);
        write_status(8'h00);
        chk8("R4 write 00", status_o, 8'h00);
        chk1("R4 no reset from write", sysrst_o, 1'b0);
    endtask

    task automatic t_por();
        write_status(8'hFC);
        @(negedge clk); por_det_i = 1'b1;
        nedge(2);
        chk8("R9 por not yet", status_o, 8'hFC);
        @(negedge clk);
        chk8("R3 por image", status_o, 8'h03);
        chk1("R1 por", sysrst_o, 1'b1);
        wr_en_i = 1'b1; wr_data_i = 8'hF0;
        @(negedge clk); wr_en_i = 1'b0;
        chk8("R3 por overrides write", status_o, 8'h03);
        por_det_i = 1'b0;
        wait_idle();
        chk8("R3 por image sticky", status_o, 8'h03);
        write_status(8'h00);
    endtask

    task automatic t_core_src(int idx);
        @(negedge clk);
        case (idx)
            3: sw_rst_i   = 1'b1;
            5: trap_cfl_i = 1'b1;
            6: bad_op_i   = 1'b1;
            default: uninit_w_i = 1'b1;
        endcase
        @(negedge clk);
        sw_rst_i = 0; trap_cfl_i = 0; bad_op_i = 0; uninit_w_i = 0;
        chk8("R2 core source bit", status_o, 8'(1 << idx));
        chk1("R1 core source", sysrst_o, 1'b1);
        wait_idle();
        write_status(8'h00);
    endtask

    task automatic t_multi();
        @(negedge clk); trap_cfl_i = 1'b1; bad_op_i = 1'b1;
        @(negedge clk); trap_cfl_i = 1'b0; bad_op_i = 1'b0;
        chk8("R2 two sources", status_o, 8'h60);
        wait_idle();
        write_status(8'h00);
    endtask

    task automatic t_wdt();
        @(negedge clk); wdt_to_i = 1'b1;
        @(negedge clk); wdt_to_i = 1'b0;
        chk8("R9 wdt not yet", status_o, 8'h00);
        nedge(2);
        chk8("R2 R9 wdt bit", status_o, 8'h10);
        chk1("R1 wdt", sysrst_o, 1'b1);
        wait_idle();
        write_status(8'h00);
    endtask

    task automatic t_hold();
        @(negedge clk); trap_cfl_i = 1'b1;
        @(negedge clk); trap_cfl_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk1("R8 hold window", sysrst_o, 1'b1);
            @(negedge clk);
        end
        chk1("R8 release", sysrst_o, 1'b0);
        write_status(8'h00);
    endtask

    task automatic t_pin();
        @(negedge clk); pin_rst_n_i = 1'b0;
        nedge(3); pin_rst_n_i = 1'b1;
        nedge(10);
        chk1("R6 glitch ignored", sysrst_o, 1'b0);
        chk8("R6 glitch ignored", status_o, 8'h00);
        @(negedge clk); pin_rst_n_i = 1'b0;
        nedge(4); pin_rst_n_i = 1'b1;
        nedge(2);
        chk8("R6 pin not yet", status_o, 8'h00);
        @(negedge clk);
        chk8("R6 pin bit", status_o, 8'h04);
        chk1("R6 pin reset", sysrst_o, 1'b1);
        wait_idle();
        write_status(8'h00);
    endtask

    task automatic t_bor(logic [1:0] mode, logic sw_en, logic slp, logic exp);
        @(negedge clk);
        bor_mode_i = mode; sw_bor_en_i = sw_en; sleep_i = slp;
        bor_det_i = 1'b1;
        nedge(2); bor_det_i = 1'b0;
        nedge(2);
        chk8("R7 bor flag", status_o, exp ? 8'h02 : 8'h00);
        chk1("R7 bor reset", sysrst_o, exp);
        wait_idle();
        write_status(8'h00);
        bor_mode_i = 2'b00; sw_bor_en_i = 1'b0; sleep_i = 1'b0;
    endtask

    task automatic t_collide();
        write_status(8'hFF);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = 8'h00; trap_cfl_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; trap_cfl_i = 1'b0;
        chk8("R5 hw set beats write", status_o, 8'h20);
        wait_idle();
        write_status(8'h00);
    endtask

    initial begin
        rst = 1'b1;
        por_det_i = 0; pin_rst_n_i = 1; bor_det_i = 0; wdt_to_i = 0;
        sw_rst_i = 0; trap_cfl_i = 0; bad_op_i = 0; uninit_w_i = 0;
        bor_mode_i = 2'b00; sw_bor_en_i = 0; sleep_i = 0;
        wr_en_i = 0; wr_data_i = '0;
        nedge(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_por();
        t_core_src(3);
        t_core_src(5);
        t_core_src(6);
        t_core_src(7);
        t_multi();
        t_wdt();
        t_hold();
        t_pin();
        t_bor(2'b00, 1'b1, 1'b0, 1'b0);
        t_bor(2'b01, 1'b0, 1'b0, 1'b0);
        t_bor(2'b01, 1'b1, 1'b0, 1'b1);
        t_bor(2'b10, 1'b0, 1'b1, 1'b0);
        t_bor(2'b10, 1'b0, 1'b0, 1'b1);
        t_bor(2'b11, 1'b0, 1'b1, 1'b1);
        t_collide();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule